// File: doc/BRIEF.md
# Per-CPU Interrupt Pending Evaluator

This block decides, for every CPU of a small cluster, whether an interrupt is waiting to be handed over, and which one. Each CPU owns a bank of private lines. A further set of shared lines is routed, one line to exactly one CPU, by a CPU index kept per shared line. The block samples every line into a register. For each CPU it masks the samples with the enable and routing inputs, and it offers the lowest-numbered eligible interrupt on a valid/ready grant port.

Each line is configured as level-triggered or edge-triggered. An edge interrupt is remembered from its rising edge until it is granted. A level interrupt follows its line. Once a level interrupt has been granted it is marked active, and the block ignores its line until an end-of-interrupt event names it again. Every grant of a level interrupt carries a flag that asks the CPU for that end-of-interrupt. A global enable holds every pending output low.

Top module: `irq_pend_eval`

## Requirements
- R1: A private interrupt is eligible for CPU c only when the sampled private line of bank c and the enable bit `priv_en_i[c*NPRIV+k]` are both 1.
- R2: A shared interrupt k is eligible for CPU c only when its sampled line is 1, `shr_en_i[k]` is 1 and the routing field `shr_tgt_i[k*CPUW +: CPUW]` equals c. No other CPU sees it.
- R3: A change on a line input shows on `pend_o` one clock after it is sampled. A change on the enable, routing or enable-all inputs shows in the same cycle.
- R4: IDs 0..NPRIV-1 name the private lines of the CPU's own bank, and IDs NPRIV..NPRIV+NSHARED-1 name the shared lines. `grant_id_o` gives the lowest eligible ID.
- R5: `cfg_edge_i[id]` = 0 selects level. A granted level interrupt (pend and ready both high at a clock edge) becomes active. It is not offered again while its line stays high, and it is offered with `grant_eoi_o` = 1.
- R6: `cfg_edge_i[id]` = 1 selects edge. A 0-to-1 change between two samples records the interrupt, and a grant clears it. A line held high after the grant is not offered again. `grant_eoi_o` is 0 for an edge interrupt.
- R7: While `dist_en_i` is 0, every bit of `pend_o` is 0.
- R8: An end-of-interrupt event clears the active mark of that ID, in the named CPU's bank for a private ID. After that the line is sampled again. An event whose ID (or, for a private ID, whose CPU) has no active mark has no effect.
- R9: A level interrupt that has not been granted stops pending once its line falls.
- R10: After reset no CPU is pending, and no active mark or recorded edge remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dist_en_i | input | 1 | Global enable for all pending outputs |
| priv_line_i | input | NCPU*NPRIV | Private line inputs, bank c at bits c*NPRIV upward |
| priv_en_i | input | NCPU*NPRIV | Private enables, banked like the lines |
| shr_line_i | input | NSHARED | Shared line inputs |
| shr_en_i | input | NSHARED | Shared enables |
| shr_tgt_i | input | NSHARED*CPUW | Destination CPU index per shared line |
| cfg_edge_i | input | NIRQ | Trigger mode per ID: 0 level, 1 edge |
| pend_o | output | NCPU | CPU has an interrupt to take (grant valid) |
| grant_ready_i | input | NCPU | CPU accepts the offered interrupt |
| grant_id_o | output | NCPU*IDW | Offered ID per CPU |
| grant_eoi_o | output | NCPU | Offered interrupt needs an end-of-interrupt |
| eoi_valid_i | input | 1 | End-of-interrupt event |
| eoi_cpu_i | input | CPUW | CPU that signals the end-of-interrupt |
| eoi_id_i | input | IDW | ID being ended |

## Verification
A vector table drives level-configured patterns with all grants held off. The patterns separate banked private lines from shared lines, set lines whose enable is off, and steer one shared line to each CPU in turn. Mixed private and shared requests show which ID wins under the lowest-number rule. Directed runs then grant a level interrupt and keep its line high, which separates active masking from plain line following. End-of-interrupt events with a wrong ID, a wrong CPU and then the right pair tell an ignored event from a real clear. An edge interrupt held high after its grant separates the recorded edge from the line level, and toggling the global enable shows the gating on its own.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_e;

  function automatic int cpu_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_line_bank.sv
module irq_line_bank
  import irq_pend_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] edge_i,
  input  logic [N-1:0] take_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] ready_o
);
  logic [N-1:0] line_q, line_d;
  logic [N-1:0] est_q, est_d;
  logic [N-1:0] act_q, act_d;
  logic [N-1:0] rise;
  logic [N-1:0] is_edge;

  always_comb begin
    for (int i = 0; i < N; i++) is_edge[i] = (edge_i[i] == TRIG_EDGE);
    rise   = line_i & ~line_q;
    line_d = line_i;
    est_d  = ((est_q & ~take_i) | rise) & is_edge;
    act_d  = (act_q | (take_i & ~is_edge)) & ~clr_i;
    ready_o = ((is_edge & est_q) | (~is_edge & line_q)) & ~act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      est_q  <= '0;
      act_q  <= '0;
    end else begin
      line_q <= line_d;
      est_q  <= est_d;
      act_q  <= act_d;
    end
  end

  // R5: a granted level line is masked on the following cycle
  assert_level_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    |(take_i & ~is_edge & ~clr_i) |=> (ready_o & $past(take_i & ~is_edge & ~clr_i)) == '0);

  // R6: a granted edge line without a fresh edge is consumed
  assert_edge_consumed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    |(take_i & is_edge & ~rise) |=> (ready_o & is_edge & $past(take_i & is_edge & ~rise)) == '0);
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = 64,
  parameter int IW = 6
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
    valid_o = |req_i;
  end
endmodule

// File: rtl/irq_pend_eval.sv
module irq_pend_eval
  import irq_pend_pkg::*;
#(
  parameter  int NCPU    = 4,
  parameter  int NPRIV   = 32,
  parameter  int NSHARED = 32,
  localparam int NIRQ    = NPRIV + NSHARED,
  localparam int IDW     = $clog2(NIRQ),
  localparam int CPUW    = cpu_w(NCPU)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dist_en_i,
  input  logic [NCPU*NPRIV-1:0]   priv_line_i,
  input  logic [NCPU*NPRIV-1:0]   priv_en_i,
  input  logic [NSHARED-1:0]      shr_line_i,
  input  logic [NSHARED-1:0]      shr_en_i,
  input  logic [NSHARED*CPUW-1:0] shr_tgt_i,
  input  logic [NIRQ-1:0]         cfg_edge_i,
  output logic [NCPU-1:0]         pend_o,
  input  logic [NCPU-1:0]         grant_ready_i,
  output logic [NCPU*IDW-1:0]     grant_id_o,
  output logic [NCPU-1:0]         grant_eoi_o,
  input  logic                    eoi_valid_i,
  input  logic [CPUW-1:0]         eoi_cpu_i,
  input  logic [IDW-1:0]          eoi_id_i
);
  localparam int PW = $clog2(NPRIV);
  localparam int SW = $clog2(NSHARED);

  logic [NSHARED-1:0] shr_rdy, shr_take, shr_clr;
  logic [NCPU-1:0]    pick_v, fire;
  logic [IDW-1:0]     pick_id [NCPU];
  logic [IDW-1:0]     shr_off [NCPU];
  logic               eoi_is_shr;
  logic [IDW-1:0]     eoi_off;

  assign eoi_is_shr = (eoi_id_i >= IDW'(NPRIV));
  assign eoi_off    = eoi_id_i - IDW'(NPRIV);

  irq_line_bank #(.N(NSHARED)) u_shr_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_i  (shr_line_i),
    .edge_i  (cfg_edge_i[NIRQ-1:NPRIV]),
    .take_i  (shr_take),
    .clr_i   (shr_clr),
    .ready_o (shr_rdy)
  );

  always_comb begin
    shr_take = '0;
    for (int c = 0; c < NCPU; c++) begin
      if (fire[c] && pick_id[c] >= IDW'(NPRIV))
        shr_take = shr_take | ({{(NSHARED-1){1'b0}}, 1'b1} << shr_off[c]);
    end
    shr_clr = (eoi_valid_i && eoi_is_shr) ? ({{(NSHARED-1){1'b0}}, 1'b1} << eoi_off) : '0;
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic [NPRIV-1:0]   prv_rdy, prv_take, prv_clr, en_c;
    logic [NSHARED-1:0] tgt_hit;
    logic [NIRQ-1:0]    elig;

    assign en_c = priv_en_i[c*NPRIV +: NPRIV];

    always_comb begin
      for (int k = 0; k < NSHARED; k++)
        tgt_hit[k] = (shr_tgt_i[k*CPUW +: CPUW] == CPUW'(c));
      elig = {shr_rdy & shr_en_i & tgt_hit, prv_rdy & en_c};
      prv_take = (fire[c] && pick_id[c] < IDW'(NPRIV))
               ? ({{(NPRIV-1){1'b0}}, 1'b1} << pick_id[c]) : '0;
      prv_clr  = (eoi_valid_i && !eoi_is_shr && eoi_cpu_i == CPUW'(c))
               ? ({{(NPRIV-1){1'b0}}, 1'b1} << eoi_id_i) : '0;
    end

    irq_line_bank #(.N(NPRIV)) u_prv_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_i  (priv_line_i[c*NPRIV +: NPRIV]),
      .edge_i  (cfg_edge_i[NPRIV-1:0]),
      .take_i  (prv_take),
      .clr_i   (prv_clr),
      .ready_o (prv_rdy)
    );

    irq_pick #(.N(NIRQ), .IW(IDW)) u_pick (
      .req_i   (elig),
      .valid_o (pick_v[c]),
      .idx_o   (pick_id[c])
    );

    assign shr_off[c]                = pick_id[c] - IDW'(NPRIV);
    assign pend_o[c]                 = dist_en_i & pick_v[c];
    assign fire[c]                   = pend_o[c] & grant_ready_i[c];
    assign grant_id_o[c*IDW +: IDW]  = pick_id[c];
    assign grant_eoi_o[c]            = pend_o[c] & (cfg_edge_i[pick_id[c]] == TRIG_LEVEL);

    // R4: offered ID is eligible and no lower ID is
    assert_lowest_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pend_o[c] |-> elig[pick_id[c]] &&
                    ((elig & ((NIRQ'(1) << pick_id[c]) - NIRQ'(1))) == '0));

    // R1: a private grant always has its banked enable set
    assert_priv_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o[c] && pick_id[c] < IDW'(NPRIV)) |-> en_c[pick_id[c][PW-1:0]]);

    // R2: a shared grant has its enable and a ready line
    assert_shr_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o[c] && pick_id[c] >= IDW'(NPRIV)) |->
        (shr_en_i[shr_off[c][SW-1:0]] && shr_rdy[shr_off[c][SW-1:0]]));

    // R5: a level grant is not repeated on the next cycle
    assert_no_regrant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire[c] && grant_eoi_o[c] && !eoi_valid_i) |=>
        (!pend_o[c] || grant_id_o[c*IDW +: IDW] != $past(grant_id_o[c*IDW +: IDW])));
  end

  // R7: global enable off holds all CPUs idle
  assert_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dist_en_i |-> pend_o == '0);
endmodule

// File: tb/irq_pend_eval_tb.sv
`timescale 1ns/1ps
module irq_pend_eval_tb;
  localparam int NCPU = 2, NPRIV = 8, NSHARED = 8;
  localparam int NIRQ = NPRIV + NSHARED, IDW = 4, CPUW = 1;

  logic clk, rst_n, dist_en;
  logic [NCPU*NPRIV-1:0] pline, pen;
  logic [NSHARED-1:0] sline, sen;
  logic [NSHARED*CPUW-1:0] stgt;
  logic [NIRQ-1:0] cfg;
  logic [NCPU-1:0] pend, gready, geoi;
  logic [NCPU*IDW-1:0] gid;
  logic eoi_v;
  logic [CPUW-1:0] eoi_cpu;
  logic [IDW-1:0] eoi_id;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  irq_pend_eval #(.NCPU(NCPU), .NPRIV(NPRIV), .NSHARED(NSHARED)) u_dut (
    .clk(clk), .rst_n(rst_n), .dist_en_i(dist_en),
    .priv_line_i(pline), .priv_en_i(pen),
    .shr_line_i(sline), .shr_en_i(sen), .shr_tgt_i(stgt),
    .cfg_edge_i(cfg), .pend_o(pend), .grant_ready_i(gready),
    .grant_id_o(gid), .grant_eoi_o(geoi),
    .eoi_valid_i(eoi_v), .eoi_cpu_i(eoi_cpu), .eoi_id_i(eoi_id)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  // fields: pline[65:50] pen[49:34] sline[33:26] sen[25:18] tgt[17:10]
  //         pend{cpu1,cpu0}[9:8] id0[7:4] id1[3:0]; all lines level
  localparam logic [65:0] TBL [0:7] = '{
    {16'h0000, 16'h0000, 8'h00, 8'h00, 8'h00, 2'b00, 4'd0,  4'd0},
    {16'h2008, 16'hFFFF, 8'h00, 8'hFF, 8'h00, 2'b11, 4'd3,  4'd5},
    {16'h0101, 16'h0100, 8'h00, 8'hFF, 8'h00, 2'b10, 4'd0,  4'd0},
    {16'h0000, 16'hFFFF, 8'h04, 8'hFF, 8'h04, 2'b10, 4'd0,  4'd10},
    {16'h0000, 16'hFFFF, 8'h04, 8'hFF, 8'h00, 2'b01, 4'd10, 4'd0},
    {16'h8000, 16'hFFFF, 8'h12, 8'hFF, 8'h10, 2'b11, 4'd9,  4'd7},
    {16'h0000, 16'hFFFF, 8'h01, 8'h00, 8'h00, 2'b00, 4'd0,  4'd0},
    {16'h0042, 16'hFFFF, 8'h01, 8'hFF, 8'h00, 2'b01, 4'd1,  4'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic grant(input int c);
    gready[c] = 1'b1;
    step();
    gready = '0;
  endtask

  task automatic eoi(input logic [CPUW-1:0] c, input logic [IDW-1:0] id);
    eoi_v = 1'b1; eoi_cpu = c; eoi_id = id;
    step();
    eoi_v = 1'b0;
  endtask

  task automatic clear_inputs();
    pline = '0; pen = '0; sline = '0; sen = '0; stgt = '0; cfg = '0;
    step(); step();
  endtask

  initial begin
    rst_n = 0; dist_en = 1; gready = '0; eoi_v = 0; eoi_cpu = '0; eoi_id = '0;
    pline = '0; pen = '0; sline = '0; sen = '0; stgt = '0; cfg = '0;
    @(negedge clk);
    pline = 16'hFFFF; pen = 16'hFFFF;
    @(negedge clk);
    // R10: reset holds everything idle
    chk("R10 pend in reset", 32'(pend), 32'h0);
    pline = '0; pen = '0;
    @(negedge clk);
    rst_n = 1;
    step();
    chk("R10 pend after reset", 32'(pend), 32'h0);

    // R1 R2 R3 R4 table walk
    for (int i = 0; i < 8; i++) begin
      logic [65:0] e;
      e = TBL[i];
      pline = e[65:50]; pen = e[49:34]; sline = e[33:26];
      sen = e[25:18]; stgt = e[17:10];
      step(); step();
      chk($sformatf("R1 R2 R3 table %0d pend", i), 32'(pend), 32'(e[9:8]));
      if (e[8]) chk($sformatf("R4 table %0d id cpu0", i), 32'(gid[3:0]), 32'(e[7:4]));
      if (e[9]) chk($sformatf("R4 table %0d id cpu1", i), 32'(gid[7:4]), 32'(e[3:0]));
    end

    // R7: global enable
    clear_inputs();
    pline = 16'h0001; pen = 16'hFFFF;
    step();
    dist_en = 0;
    #0.5;
    chk("R7 disabled pend", 32'(pend), 32'h0);
    dist_en = 1;
    #0.5;
    chk("R7 re-enabled pend", 32'(pend), 32'h1);
    @(negedge clk);

    // R5 R8 R9: level interrupt on cpu0 private line 2
    clear_inputs();
    pline = 16'h0004; pen = 16'hFFFF;
    step();
    chk("R3 level pend", 32'(pend), 32'h1);
    chk("R4 level id", 32'(gid[3:0]), 32'd2);
    chk("R5 level eoi flag", 32'(geoi[0]), 32'h1);
    grant(0);
    chk("R5 masked after grant", 32'(pend), 32'h0);
    step(); step();
    chk("R5 still masked", 32'(pend), 32'h0);
    eoi(1'b0, 4'd3);
    chk("R8 wrong id ignored", 32'(pend), 32'h0);
    eoi(1'b1, 4'd2);
    chk("R8 wrong cpu ignored", 32'(pend), 32'h0);
    eoi(1'b0, 4'd2);
    chk("R8 eoi restores pend", 32'(pend), 32'h1);
    chk("R8 eoi restores id", 32'(gid[3:0]), 32'd2);
    pline = 16'h0000;
    step();
    chk("R9 line drop clears pend", 32'(pend), 32'h0);

    // R6: edge interrupt on shared id 11 routed to cpu1
    clear_inputs();
    cfg = 16'h0800; sen = 8'hFF; stgt = 8'h08;
    sline = 8'h08;
    step();
    chk("R6 edge pend", 32'(pend), 32'h2);
    chk("R6 edge id", 32'(gid[7:4]), 32'd11);
    chk("R6 edge eoi flag", 32'(geoi[1]), 32'h0);
    grant(1);
    chk("R6 consumed while high", 32'(pend), 32'h0);
    step();
    chk("R6 no re-delivery", 32'(pend), 32'h0);
    sline = 8'h00;
    step();
    sline = 8'h08;
    step();
    chk("R6 new edge pends", 32'(pend), 32'h2);
    eoi(1'b1, 4'd11);
    chk("R8 eoi on edge ignored", 32'(pend), 32'h2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule